// File: doc/BRIEF.md
# Sleep-Wake Mode Sequencer

This block is the power-mode controller of an isolated node that spends most of its life asleep. It starts in a low-power sleep phase and requests sleep from the rest of the node. A qualified wake pulse moves it to a detect phase. It then waits for the wake qualifier to report that it has finished. If the far-side handshake is enabled, it waits for a READY acknowledgement and then opens the data path. If it is disabled, it opens the data path directly.

Data is declared valid only once the handshake is complete. If READY does not arrive within a programmed number of cycles, the sequencer stops in a fail-safe phase and stays there until reset. It never enters the active phase in that case. An idle timer in the active phase starts a return phase that ends in sleep. Bus activity seen during the return phase cancels it.

Each phase boundary of a wake (detect, handshake, valid) produces a one-cycle strobe. A counter reports the detect-to-valid latency in clock cycles, so each wake interval can be measured.

Top module: `sleep_wake_seq`

## Requirements
- R1: A synchronous active-high reset forces the sleep phase. After reset, sleep_req_o is 1, and data_valid_o, dp_en_o, failsafe_o, all strobes and lat_o are 0.
- R2: In the sleep phase, wake_qual_i high at a clock edge moves the machine to the detect phase at that edge, and stb_detect_o is high for exactly that one cycle.
- R3: The detect phase holds until qual_done_i is high. At that edge the machine moves to the handshake phase if hs_en_i is 1, and stb_hs_o pulses for one cycle. If hs_en_i is 0, it moves straight to the active phase.
- R4: The handshake phase lasts at most hs_timeout_i cycles. ready_i high in any of those cycles, including the last one, moves the machine to the active phase. Otherwise the machine enters the fail-safe phase at the edge that ends the last cycle.
- R5: data_valid_o is 1 only in the active and return phases. dp_en_o is 1 in the handshake, active and return phases and 0 otherwise.
- R6: The fail-safe phase drives failsafe_o to 1 with dp_en_o and data_valid_o at 0. It ignores every input and is left only through reset.
- R7: The active phase moves to the return phase after idle_timeout_i consecutive cycles with activity_i low. Any cycle with activity_i high restarts that count.
- R8: The return phase lasts RET_CYCLES cycles and then goes to the sleep phase, where data_valid_o drops. activity_i high during the return phase goes back to the active phase, keeps data_valid_o at 1 and does not pulse stb_valid_o.
- R9: stb_valid_o pulses for one cycle on entry to the active phase from detect or handshake. At the same edge, lat_o takes the number of cycles from the stb_detect_o pulse to the stb_valid_o pulse, saturating at its maximum.
- R10: state_o encodes the phases as sleep 0, detect 1, handshake 2, active 3, return 4, fail-safe 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_qual_i | input | 1 | Qualified wake pulse |
| qual_done_i | input | 1 | Wake qualifier has finished |
| ready_i | input | 1 | READY acknowledgement from the far side |
| activity_i | input | 1 | Bus activity indication |
| hs_en_i | input | 1 | Handshake phase enable |
| hs_timeout_i | input | TMR_W | Handshake timeout in cycles |
| idle_timeout_i | input | TMR_W | Idle cycles before return |
| state_o | output | 3 | Current phase code |
| dp_en_o | output | 1 | Data-path enable |
| data_valid_o | output | 1 | Data valid for sampling |
| sleep_req_o | output | 1 | Sleep request |
| failsafe_o | output | 1 | Fail-safe entered |
| stb_detect_o | output | 1 | Strobe: detect phase entered |
| stb_hs_o | output | 1 | Strobe: handshake phase entered |
| stb_valid_o | output | 1 | Strobe: data valid after wake |
| lat_o | output | LAT_W | Detect-to-valid latency in cycles |

## Verification
Every output is a register loaded from the next-phase decode. A phase change caused by inputs present before edge N therefore appears on all outputs, strobes and lat_o just after edge N, exactly one edge after the stimulus. The bench drives inputs and samples outputs 1 ns after each rising edge, so each check counts edges from the stimulus. For the timed phases it checks the last cycle still in a phase and the first cycle of the next one: hs_timeout_i, idle_timeout_i and RET_CYCLES edges after entry. Expected latencies follow from the number of edges spent in detect and handshake.

// File: rtl/swq_pkg.sv
package swq_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP    = 3'd0,
    ST_DETECT   = 3'd1,
    ST_HSHAKE   = 3'd2,
    ST_ACTIVE   = 3'd3,
    ST_RETURN   = 3'd4,
    ST_FAILSAFE = 3'd5
  } swq_state_e;

  function automatic logic is_wake_phase(swq_state_e s);
    return (s == ST_DETECT) || (s == ST_HSHAKE);
  endfunction
endpackage

// File: rtl/swq_timer.sv
module swq_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_o <= '0;
    end else if (cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/swq_fsm.sv
module swq_fsm
  import swq_pkg::*;
#(
  parameter int TMR_W      = 16,
  parameter int RET_CYCLES = 4,
  parameter int CNT_W      = TMR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake_qual_i,
  input  logic             qual_done_i,
  input  logic             ready_i,
  input  logic             activity_i,
  input  logic             hs_en_i,
  input  logic [TMR_W-1:0] hs_timeout_i,
  input  logic [TMR_W-1:0] idle_timeout_i,
  input  logic [CNT_W-1:0] tmr_cnt_i,
  output swq_state_e       st_o,
  output swq_state_e       nxt_o,
  output logic             tmr_clr_o,
  output logic             dp_en_o,
  output logic             data_valid_o,
  output logic             sleep_req_o,
  output logic             failsafe_o,
  output logic             stb_detect_o,
  output logic             stb_hs_o,
  output logic             stb_valid_o
);
  localparam int EW = CNT_W + 1;
  localparam logic [EW-1:0] RET_LIM = EW'(RET_CYCLES);

  swq_state_e st, nxt;
  logic [EW-1:0] elapsed;
  logic hs_expired, idle_expired, ret_expired;

  assign elapsed      = EW'(tmr_cnt_i) + 1'b1;
  assign hs_expired   = elapsed >= EW'(hs_timeout_i);
  assign idle_expired = elapsed >= EW'(idle_timeout_i);
  assign ret_expired  = elapsed >= RET_LIM;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_SLEEP:  if (wake_qual_i) nxt = ST_DETECT;
      ST_DETECT: if (qual_done_i) nxt = hs_en_i ? ST_HSHAKE : ST_ACTIVE;
      ST_HSHAKE: begin
        if (ready_i)         nxt = ST_ACTIVE;
        else if (hs_expired) nxt = ST_FAILSAFE;
      end
      ST_ACTIVE: if (!activity_i && idle_expired) nxt = ST_RETURN;
      ST_RETURN: begin
        if (activity_i)       nxt = ST_ACTIVE;
        else if (ret_expired) nxt = ST_SLEEP;
      end
      ST_FAILSAFE: nxt = ST_FAILSAFE;
      default:     nxt = ST_SLEEP;
    endcase
  end

  assign tmr_clr_o = (nxt != st) || ((st == ST_ACTIVE) && activity_i);
  assign st_o      = st;
  assign nxt_o     = nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_SLEEP;
      dp_en_o      <= 1'b0;
      data_valid_o <= 1'b0;
      sleep_req_o  <= 1'b1;
      failsafe_o   <= 1'b0;
      stb_detect_o <= 1'b0;
      stb_hs_o     <= 1'b0;
      stb_valid_o  <= 1'b0;
    end else begin
      st           <= nxt;
      dp_en_o      <= (nxt == ST_HSHAKE) || (nxt == ST_ACTIVE) || (nxt == ST_RETURN);
      data_valid_o <= (nxt == ST_ACTIVE) || (nxt == ST_RETURN);
      sleep_req_o  <= (nxt == ST_SLEEP);
      failsafe_o   <= (nxt == ST_FAILSAFE);
      stb_detect_o <= (st == ST_SLEEP) && (nxt == ST_DETECT);
      stb_hs_o     <= (st == ST_DETECT) && (nxt == ST_HSHAKE);
      stb_valid_o  <= is_wake_phase(st) && (nxt == ST_ACTIVE);
    end
  end
endmodule

// File: rtl/swq_latency.sv
module swq_latency
  import swq_pkg::*;
#(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  swq_state_e       st_i,
  input  swq_state_e       nxt_i,
  output logic [LAT_W-1:0] lat_o
);
  localparam logic [LAT_W-1:0] LAT_MAX = '1;

  logic [LAT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      lat_o   <= '0;
    end else begin
      if ((st_i == ST_SLEEP) && (nxt_i == ST_DETECT)) begin
        run_cnt <= LAT_W'(1);
      end else if (is_wake_phase(st_i) && (run_cnt != LAT_MAX)) begin
        run_cnt <= run_cnt + 1'b1;
      end
      if (is_wake_phase(st_i) && (nxt_i == ST_ACTIVE)) begin
        lat_o <= run_cnt;
      end
    end
  end
endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
  import swq_pkg::*;
#(
  parameter int TMR_W      = 16,
  parameter int RET_CYCLES = 4,
  parameter int LAT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake_qual_i,
  input  logic             qual_done_i,
  input  logic             ready_i,
  input  logic             activity_i,
  input  logic             hs_en_i,
  input  logic [TMR_W-1:0] hs_timeout_i,
  input  logic [TMR_W-1:0] idle_timeout_i,
  output logic [2:0]       state_o,
  output logic             dp_en_o,
  output logic             data_valid_o,
  output logic             sleep_req_o,
  output logic             failsafe_o,
  output logic             stb_detect_o,
  output logic             stb_hs_o,
  output logic             stb_valid_o,
  output logic [LAT_W-1:0] lat_o
);
  localparam int CNT_W = TMR_W + 1;

  swq_state_e       st, nxt;
  logic             tmr_clr;
  logic [CNT_W-1:0] tmr_cnt;

  swq_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .cnt_o (tmr_cnt)
  );

  swq_fsm #(
    .TMR_W      (TMR_W),
    .RET_CYCLES (RET_CYCLES),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .wake_qual_i    (wake_qual_i),
    .qual_done_i    (qual_done_i),
    .ready_i        (ready_i),
    .activity_i     (activity_i),
    .hs_en_i        (hs_en_i),
    .hs_timeout_i   (hs_timeout_i),
    .idle_timeout_i (idle_timeout_i),
    .tmr_cnt_i      (tmr_cnt),
    .st_o           (st),
    .nxt_o          (nxt),
    .tmr_clr_o      (tmr_clr),
    .dp_en_o        (dp_en_o),
    .data_valid_o   (data_valid_o),
    .sleep_req_o    (sleep_req_o),
    .failsafe_o     (failsafe_o),
    .stb_detect_o   (stb_detect_o),
    .stb_hs_o       (stb_hs_o),
    .stb_valid_o    (stb_valid_o)
  );

  swq_latency #(.LAT_W(LAT_W)) u_lat (
    .clk   (clk),
    .rst   (rst),
    .st_i  (st),
    .nxt_i (nxt),
    .lat_o (lat_o)
  );

  assign state_o = st;
endmodule

// File: rtl/swq_checker.sv
module swq_checker (
  input logic       clk,
  input logic       rst,
  input logic       wake_qual_i,
  input logic [2:0] state_o,
  input logic       dp_en_o,
  input logic       data_valid_o,
  input logic       sleep_req_o,
  input logic       failsafe_o,
  input logic       stb_detect_o,
  input logic       stb_hs_o,
  input logic       stb_valid_o
);
  assert_valid_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    data_valid_o |-> dp_en_o);

  assert_wake_to_detect_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && wake_qual_i) |=> stb_detect_o);

  assert_failsafe_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    failsafe_o |=> (failsafe_o && !dp_en_o && !data_valid_o));

  assert_failsafe_from_hs_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(failsafe_o) |-> ($past(state_o) == 3'd2));

  assert_strobes_single_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb_detect_o, stb_hs_o, stb_valid_o}));

  assert_valid_strobe_dv_R9: assert property (@(posedge clk) disable iff (rst)
    stb_valid_o |-> data_valid_o);

  assert_valid_falls_to_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(data_valid_o) |-> sleep_req_o);
endmodule

bind sleep_wake_seq swq_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .wake_qual_i  (wake_qual_i),
  .state_o      (state_o),
  .dp_en_o      (dp_en_o),
  .data_valid_o (data_valid_o),
  .sleep_req_o  (sleep_req_o),
  .failsafe_o   (failsafe_o),
  .stb_detect_o (stb_detect_o),
  .stb_hs_o     (stb_hs_o),
  .stb_valid_o  (stb_valid_o)
);

// File: tb/sleep_wake_seq_tb.sv
`timescale 1ns/1ps
module sleep_wake_seq_tb;
  localparam int TMR_W = 16;
  localparam int LAT_W = 16;
  localparam int RET_C = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake = 1'b0, qdone = 1'b0, rdy = 1'b0, act = 1'b0, hs_en = 1'b1;
  logic [TMR_W-1:0] hs_to = 16'd8, idle_to = 16'd5;
  logic [2:0] state;
  logic dp_en, dv, sreq, fs, s_det, s_hs, s_val;
  logic [LAT_W-1:0] lat;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sleep_wake_seq #(.TMR_W(TMR_W), .RET_CYCLES(RET_C), .LAT_W(LAT_W)) u_dut (
    .clk(clk), .rst(rst), .wake_qual_i(wake), .qual_done_i(qdone), .ready_i(rdy),
    .activity_i(act), .hs_en_i(hs_en), .hs_timeout_i(hs_to), .idle_timeout_i(idle_to),
    .state_o(state), .dp_en_o(dp_en), .data_valid_o(dv), .sleep_req_o(sreq),
    .failsafe_o(fs), .stb_detect_o(s_det), .stb_hs_o(s_hs), .stb_valid_o(s_val),
    .lat_o(lat)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, string what, int act_v, int exp_v);
    n_run++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic do_reset();
    wake = 0; qdone = 0; rdy = 0; act = 0;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  // Wake from sleep and enter handshake after one detect cycle
  task automatic enter_hs();
    wake = 1; step(); wake = 0;
    qdone = 1; step(); qdone = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "sleep_req", sreq, 1);
    chk("R1", "data_valid", dv, 0);
    chk("R1", "dp_en", dp_en, 0);
    chk("R1", "failsafe", fs, 0);
    chk("R1", "strobes", {s_det, s_hs, s_val}, 0);
    chk("R1", "lat", lat, 0);
    chk("R10", "state sleep", state, 0);
  endtask

  task automatic t_full_wake();
    do_reset();
    hs_en = 1; hs_to = 16'd8; idle_to = 16'd5;
    wake = 1; step(); wake = 0;
    chk("R2", "state detect", state, 1);
    chk("R2", "stb_detect", s_det, 1);
    step(2);
    chk("R3", "held in detect", state, 1);
    chk("R2", "stb_detect one cycle", s_det, 0);
    qdone = 1; step(); qdone = 0;
    chk("R3", "state handshake", state, 2);
    chk("R3", "stb_hs", s_hs, 1);
    chk("R5", "dp_en in hs", dp_en, 1);
    chk("R5", "dv low in hs", dv, 0);
    step(2);
    chk("R4", "waiting in hs", state, 2);
    rdy = 1; step(); rdy = 0;
    chk("R4", "state active", state, 3);
    chk("R9", "stb_valid", s_val, 1);
    chk("R9", "latency", lat, 6);
    chk("R5", "dv in active", dv, 1);
    // idle timeout
    step(4);
    chk("R7", "still active", state, 3);
    chk("R9", "stb_valid one cycle", s_val, 0);
    step();
    chk("R7", "state return", state, 4);
    chk("R8", "dv kept in return", dv, 1);
    act = 1; step(); act = 0;
    chk("R8", "return cancelled", state, 3);
    chk("R8", "dv not dropped", dv, 1);
    chk("R8", "no stb_valid on cancel", s_val, 0);
    // activity restarts idle count
    step(2);
    act = 1; step(); act = 0;
    step(4);
    chk("R7", "activity restarted idle", state, 3);
    step();
    chk("R7", "return after restart", state, 4);
    step(RET_C - 1);
    chk("R8", "return held", state, 4);
    step();
    chk("R8", "back to sleep", state, 0);
    chk("R8", "dv dropped", dv, 0);
    chk("R5", "dp_en off in sleep", dp_en, 0);
    chk("R8", "sleep_req", sreq, 1);
  endtask

  task automatic t_bypass();
    do_reset();
    hs_en = 0;
    wake = 1; step(); wake = 0;
    qdone = 1; step(); qdone = 0;
    chk("R3", "bypass to active", state, 3);
    chk("R3", "no stb_hs", s_hs, 0);
    chk("R9", "stb_valid bypass", s_val, 1);
    chk("R9", "latency bypass", lat, 1);
    chk("R5", "dp_en and dv", {dp_en, dv}, 3);
    hs_en = 1;
  endtask

  task automatic t_timeout();
    do_reset();
    hs_en = 1; hs_to = 16'd3;
    enter_hs();
    step(2);
    chk("R4", "hs before timeout", state, 2);
    chk("R5", "dv low before ready", dv, 0);
    step();
    chk("R4", "timeout to failsafe", state, 5);
    chk("R6", "failsafe flag", fs, 1);
    chk("R6", "outputs forced", {dp_en, dv}, 0);
    wake = 1; qdone = 1; rdy = 1; act = 1;
    step(3);
    wake = 0; qdone = 0; rdy = 0; act = 0;
    chk("R6", "failsafe held", state, 5);
    chk("R6", "dv still low", dv, 0);
    do_reset();
    chk("R1", "reset leaves failsafe", state, 0);
    chk("R1", "failsafe cleared", fs, 0);
  endtask

  task automatic t_ready_last();
    do_reset();
    hs_en = 1; hs_to = 16'd3;
    enter_hs();
    step(2);
    rdy = 1; step(); rdy = 0;
    chk("R4", "ready on last cycle wins", state, 3);
    chk("R9", "latency last cycle", lat, 4);
    rst = 1; step(); rst = 0;
    chk("R1", "reset from active", state, 0);
    chk("R1", "dv low after reset", dv, 0);
  endtask

  initial begin
    t_reset();
    t_full_wake();
    t_bypass();
    t_timeout();
    t_ready_last();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
    end
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule